// File: doc/BRIEF.md
# Buffered synchronous serial port

A full-duplex serial port with a transmit section and a receive section that run independently. Each section has its own bit clock input and its own frame-sync input. The host writes an outgoing 8-bit word into a transmit data register. When a frame starts, that word is copied into a shift register and sent out MSB first on the data-out pin. Incoming bits are shifted into a receive shift register. Each completed word goes to a buffer register, and from there to a data register that the host reads. Because there are three receive stages, shifting, buffer transfer and host reads can all happen at once.

Both bit clocks are sampled and edge-detected in the system clock domain. The system clock must therefore run at least four times faster than either bit clock. The host uses a small 32-bit register bus with four word addresses. Ready levels and one-cycle event pulses serve as interrupt and DMA requests.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, control and status read as 0, `tx_dat_o`, `tx_ready_o` and `rx_ready_o` are low, and both sections are disabled.
- R2: A word starts on the bit-clock rising edge after one on which frame sync is sampled high. Frame sync is accepted while a section is idle, and on the edge that carries the last bit of a word, which allows back-to-back words. Frame sync on any other mid-word edge is ignored.
- R3: The transmitter drives the word MSB first, one bit per bit-clock rising edge. `tx_dat_o` is low when no word is being sent.
- R4: A write to address 1 loads bits [7:0] into the transmit data register. `tx_ready_o` (status bit 0) is high while the transmit section is enabled and that register is empty. `tx_evt_o` pulses once each time a written word is taken for shifting.
- R5: If a frame starts with the transmit data register empty, the last word sent is sent again (0 if nothing has been sent since enable), and sticky underflow status bit 2 is set.
- R6: The receiver samples `rx_dat_i` MSB first on bit-clock rising edges. A completed word appears at address 0, bits [7:0]. `rx_ready_o` (status bit 1) goes high and `rx_evt_o` pulses once per word entering the data register.
- R7: A read strobe at address 0 empties the receive data register. A word waiting in the buffer then moves into the data register, so two received words can wait for the host.
- R8: A word that completes while both the buffer and the data register are full is discarded, and sticky overrun status bit 3 is set.
- R9: Writing status (address 3) with bit 2 or bit 3 set clears the matching sticky flag and leaves the other flag unchanged.
- R10: Control (address 2) bit 0 enables transmit and bit 1 enables receive. Clearing a bit empties that section's registers and flags. Transmit data writes made while transmit is disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Word address: 0 rx data, 1 tx data, 2 control, 3 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| tx_clk_i | input | 1 | Transmit bit clock |
| tx_fs_i | input | 1 | Transmit frame sync |
| tx_dat_o | output | 1 | Serial data out |
| rx_clk_i | input | 1 | Receive bit clock |
| rx_fs_i | input | 1 | Receive frame sync |
| rx_dat_i | input | 1 | Serial data in |
| tx_ready_o | output | 1 | Transmit data register empty |
| tx_evt_o | output | 1 | Pulse: transmit word taken |
| rx_ready_o | output | 1 | Receive data register holds a word |
| rx_evt_o | output | 1 | Pulse: word entered receive data register |

## Verification
The hardest condition to reach is overrun. Two words must already be parked in the receive pipeline while a third is still shifting in, and this happens only when frames run back to back and the host does not read. The stimulus streams three receive words, raising frame sync on each last-bit edge and issuing no read. It then drains the two survivors to confirm they are in order and that the third was dropped. The same back-to-back stream runs the transmitter out of data on its third word, which exercises underflow repetition in the same run.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  localparam int CTRL_TX_EN  = 0;
  localparam int CTRL_RX_EN  = 1;
  localparam int STAT_TX_RDY = 0;
  localparam int STAT_RX_RDY = 1;
  localparam int STAT_TX_UFL = 2;
  localparam int STAT_RX_OVR = 3;
endpackage

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic fs_i,
  input  logic dat_i,
  output logic rise_o,
  output logic fs_o,
  output logic dat_o
);
  logic [STAGES:0]   clk_q;
  logic [STAGES-1:0] fs_q;
  logic [STAGES-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= '0;
      fs_q  <= '0;
      dat_q <= '0;
    end else begin
      clk_q <= {clk_q[STAGES-1:0], sclk_i};
      fs_q  <= {fs_q[STAGES-2:0], fs_i};
      dat_q <= {dat_q[STAGES-2:0], dat_i};
    end
  end

  // fs/dat taken from the same stage as the edge, so they match the edge
  assign rise_o = clk_q[STAGES-1] & ~clk_q[STAGES];
  assign fs_o   = fs_q[STAGES-1];
  assign dat_o  = dat_q[STAGES-1];
endmodule

// File: rtl/ssp_frame_ctl.sv
module ssp_frame_ctl #(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rise_i,
  input  logic fs_i,
  output logic start_o,
  output logic shift_o,
  output logic last_o
);
  localparam int CW = $clog2(WIDTH);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign accept  = !armed_q && (cnt_q <= CW'(1));
  assign start_o = rise_i && armed_q;
  assign shift_o = rise_i && !armed_q && (cnt_q != '0);
  assign last_o  = shift_o && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (rise_i) begin
      armed_q <= accept && fs_i;
      if (armed_q)            cnt_q <= CW'(WIDTH-1);
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end
  end

  a_r2_mid_word_fs_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rise_i && !armed_q && cnt_q > CW'(1)) |=> !armed_q);
  a_r2_start_loads_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_o) |=> (cnt_q == CW'(WIDTH-1)) && !armed_q);
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rise_i,
  input  logic             start_i,
  input  logic             shift_i,
  input  logic             ufl_clr_i,
  output logic             dat_o,
  output logic             ready_o,
  output logic             evt_o,
  output logic             ufl_o
);
  logic [WIDTH-1:0] hold_q, sh_q, last_q;
  logic             full_q, act_q, ufl_q, evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0; sh_q <= '0; last_q <= '0;
      full_q <= 1'b0; act_q <= 1'b0; ufl_q <= 1'b0; evt_q <= 1'b0;
    end else if (!en_i) begin
      hold_q <= '0; sh_q <= '0; last_q <= '0;
      full_q <= 1'b0; act_q <= 1'b0; ufl_q <= 1'b0; evt_q <= 1'b0;
    end else begin
      evt_q <= start_i && full_q;
      if (start_i) begin
        sh_q  <= full_q ? hold_q : last_q;
        act_q <= 1'b1;
        if (full_q) last_q <= hold_q;
      end else if (shift_i) begin
        sh_q <= {sh_q[WIDTH-2:0], 1'b0};
      end else if (rise_i) begin
        act_q <= 1'b0;
      end
      if (wr_i) begin
        hold_q <= wdata_i;
        full_q <= 1'b1;
      end else if (start_i) begin
        full_q <= 1'b0;
      end
      if (start_i && !full_q) ufl_q <= 1'b1;
      else if (ufl_clr_i)     ufl_q <= 1'b0;
    end
  end

  assign dat_o   = act_q && sh_q[WIDTH-1];
  assign ready_o = en_i && !full_q;
  assign evt_o   = evt_q;
  assign ufl_o   = ufl_q;

  a_r5_underflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ufl_q && !ufl_clr_i) |=> ufl_q);
  a_r4_ready_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i && full_q && !wr_i) |=> (ready_o || !en_i));
  a_r3_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rise_i && !start_i && !shift_i) |=> !dat_o);
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dat_i,
  input  logic             start_i,
  input  logic             shift_i,
  input  logic             last_i,
  input  logic             rd_i,
  input  logic             ovr_clr_i,
  output logic [WIDTH-1:0] data_o,
  output logic             ready_o,
  output logic             evt_o,
  output logic             ovr_o
);
  logic [WIDTH-1:0] rsr_q, rbr_q, drr_q, word;
  logic             buf_full_q, drr_full_q, ovr_q, evt_q, take;

  assign word = {rsr_q[WIDTH-2:0], dat_i};
  assign take = buf_full_q && !drr_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsr_q <= '0; rbr_q <= '0; drr_q <= '0;
      buf_full_q <= 1'b0; drr_full_q <= 1'b0; ovr_q <= 1'b0; evt_q <= 1'b0;
    end else if (!en_i) begin
      rsr_q <= '0; rbr_q <= '0; drr_q <= '0;
      buf_full_q <= 1'b0; drr_full_q <= 1'b0; ovr_q <= 1'b0; evt_q <= 1'b0;
    end else begin
      evt_q <= take;
      if (start_i || shift_i) rsr_q <= word;
      if (take) begin
        drr_q      <= rbr_q;
        drr_full_q <= 1'b1;
      end else if (rd_i && drr_full_q) begin
        drr_full_q <= 1'b0;
      end
      // buffer frees in the same cycle it hands over
      if (last_i && (!buf_full_q || take)) begin
        rbr_q      <= word;
        buf_full_q <= 1'b1;
      end else if (take) begin
        buf_full_q <= 1'b0;
      end
      if (last_i && buf_full_q && drr_full_q) ovr_q <= 1'b1;
      else if (ovr_clr_i)                     ovr_q <= 1'b0;
    end
  end

  assign data_o  = drr_q;
  assign ready_o = drr_full_q;
  assign evt_o   = evt_q;
  assign ovr_o   = ovr_q;

  a_r7_hold_until_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && drr_full_q && !rd_i) |=> (!en_i || (drr_full_q && $stable(drr_q))));
  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ovr_q && !ovr_clr_i) |=> ovr_q);
  a_r8_discard_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && last_i && buf_full_q && drr_full_q) |=> (!en_i || $stable(rbr_q)));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int BUS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [BUS_W-1:0] reg_wdata_i,
  output logic [BUS_W-1:0] reg_rdata_o,
  input  logic             tx_clk_i,
  input  logic             tx_fs_i,
  output logic             tx_dat_o,
  input  logic             rx_clk_i,
  input  logic             rx_fs_i,
  input  logic             rx_dat_i,
  output logic             tx_ready_o,
  output logic             tx_evt_o,
  output logic             rx_ready_o,
  output logic             rx_evt_o
);
  localparam int PAD_W = BUS_W - WORD_W;

  logic [1:0]        ctrl_q;
  logic              tx_en, rx_en, tx_wr, rx_rd, ufl_clr, ovr_clr;
  logic              tx_rise, tx_fs, tx_start, tx_shift;
  logic              rx_rise, rx_fs, rx_dat, rx_start, rx_shift, rx_last;
  logic              tx_ufl, rx_ovr;
  logic [WORD_W-1:0] rx_data;
  logic              unused_tx_dat, unused_tx_last, unused_bits;

  assign tx_en   = ctrl_q[CTRL_TX_EN];
  assign rx_en   = ctrl_q[CTRL_RX_EN];
  assign tx_wr   = reg_wr_i && (reg_addr_i == REG_TXD);
  assign rx_rd   = reg_rd_i && (reg_addr_i == REG_RXD);
  assign ufl_clr = reg_wr_i && (reg_addr_i == REG_STAT) && reg_wdata_i[STAT_TX_UFL];
  assign ovr_clr = reg_wr_i && (reg_addr_i == REG_STAT) && reg_wdata_i[STAT_RX_OVR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        ctrl_q <= '0;
    else if (reg_wr_i && (reg_addr_i == REG_CTRL))      ctrl_q <= reg_wdata_i[1:0];
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_RXD:  reg_rdata_o = {{PAD_W{1'b0}}, rx_data};
      REG_CTRL: reg_rdata_o[1:0] = ctrl_q;
      REG_STAT: begin
        reg_rdata_o[STAT_TX_RDY] = tx_ready_o;
        reg_rdata_o[STAT_RX_RDY] = rx_ready_o;
        reg_rdata_o[STAT_TX_UFL] = tx_ufl;
        reg_rdata_o[STAT_RX_OVR] = rx_ovr;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
    .clk_i, .rst_ni, .sclk_i(tx_clk_i), .fs_i(tx_fs_i), .dat_i(1'b0),
    .rise_o(tx_rise), .fs_o(tx_fs), .dat_o(unused_tx_dat));

  ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
    .clk_i, .rst_ni, .sclk_i(rx_clk_i), .fs_i(rx_fs_i), .dat_i(rx_dat_i),
    .rise_o(rx_rise), .fs_o(rx_fs), .dat_o(rx_dat));

  ssp_frame_ctl #(.WIDTH(WORD_W)) u_tx_frame (
    .clk_i, .rst_ni, .en_i(tx_en), .rise_i(tx_rise), .fs_i(tx_fs),
    .start_o(tx_start), .shift_o(tx_shift), .last_o(unused_tx_last));

  ssp_frame_ctl #(.WIDTH(WORD_W)) u_rx_frame (
    .clk_i, .rst_ni, .en_i(rx_en), .rise_i(rx_rise), .fs_i(rx_fs),
    .start_o(rx_start), .shift_o(rx_shift), .last_o(rx_last));

  ssp_tx #(.WIDTH(WORD_W)) u_tx (
    .clk_i, .rst_ni, .en_i(tx_en), .wr_i(tx_wr), .wdata_i(reg_wdata_i[WORD_W-1:0]),
    .rise_i(tx_rise), .start_i(tx_start), .shift_i(tx_shift), .ufl_clr_i(ufl_clr),
    .dat_o(tx_dat_o), .ready_o(tx_ready_o), .evt_o(tx_evt_o), .ufl_o(tx_ufl));

  ssp_rx #(.WIDTH(WORD_W)) u_rx (
    .clk_i, .rst_ni, .en_i(rx_en), .dat_i(rx_dat), .start_i(rx_start),
    .shift_i(rx_shift), .last_i(rx_last), .rd_i(rx_rd), .ovr_clr_i(ovr_clr),
    .data_o(rx_data), .ready_o(rx_ready_o), .evt_o(rx_evt_o), .ovr_o(rx_ovr));

  assign unused_bits = ^{reg_wdata_i[BUS_W-1:WORD_W], unused_tx_dat, unused_tx_last};

  a_r10_tx_off_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en |-> !tx_ready_o && !tx_dat_o);
  a_r10_rx_off_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en && $past(!rx_en) |-> !rx_ready_o);
endmodule

// File: tb/sync_serial_port_tb_top.sv
module sync_serial_port_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_clk = 1'b0, tx_fs = 1'b0, rx_clk = 1'b0, rx_fs = 1'b0, rx_dat = 1'b0;
  logic        tx_dat, tx_ready, tx_evt, rx_ready, rx_evt;

  always #10 clk = ~clk;

  sync_serial_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_clk_i(tx_clk), .tx_fs_i(tx_fs), .tx_dat_o(tx_dat),
    .rx_clk_i(rx_clk), .rx_fs_i(rx_fs), .rx_dat_i(rx_dat),
    .tx_ready_o(tx_ready), .tx_evt_o(tx_evt), .rx_ready_o(rx_ready), .rx_evt_o(rx_evt));

  int tests = 0, fails = 0, quiet = 0;
  bit run = 0;
  int n_txevt = 0, n_rxevt = 0;

  // behavioural reference model
  bit m_tx_en, m_rx_en, m_ufl, m_ovr, m_txd;
  bit t_arm, t_act, r_arm;
  int t_cnt, t_word, t_pend = -1, t_last, m_txevt;
  int r_cnt, r_sh, m_rxevt;
  int rxq[$];

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int exp_stat();
    return (int'(m_ovr) << 3) | (int'(m_ufl) << 2) | (int'(rxq.size() > 0) << 1)
           | int'(m_tx_en && t_pend < 0);
  endfunction

  always @(posedge clk) begin
    if (tx_evt) n_txevt++;
    if (rx_evt) n_rxevt++;
  end

  always @(negedge clk) begin
    if (run) begin
      if (quiet > 0) quiet--;
      else begin
        chk("R3 tx_dat_o", int'(tx_dat), int'(m_txd));
        chk("R4 tx_ready_o", int'(tx_ready), int'(m_tx_en && t_pend < 0));
        chk("R6 rx_ready_o", int'(rx_ready), int'(rxq.size() > 0));
      end
    end
  end

  task automatic model_rise(bit fs, bit rb);
    bit acc;
    if (m_tx_en) begin
      acc = !t_arm && t_cnt <= 1;
      if (t_arm) begin
        if (t_pend >= 0) begin t_word = t_pend; t_pend = -1; m_txevt++; end
        else begin t_word = t_last; m_ufl = 1; end
        t_last = t_word; t_cnt = 7; t_act = 1; t_arm = 0;
        m_txd = t_word[7];
      end else if (t_cnt > 0) begin
        t_cnt--; m_txd = t_word[t_cnt];
      end else begin
        t_act = 0; m_txd = 0;
      end
      if (acc && fs) t_arm = 1;
    end
    if (m_rx_en) begin
      acc = !r_arm && r_cnt <= 1;
      if (r_arm) begin
        r_sh = int'(rb); r_cnt = 7; r_arm = 0;
      end else if (r_cnt > 0) begin
        r_sh = ((r_sh << 1) | int'(rb)) & 255; r_cnt--;
        if (r_cnt == 0) begin
          if (rxq.size() < 2) begin
            if (rxq.size() == 0) m_rxevt++;
            rxq.push_back(r_sh);
          end else m_ovr = 1;
        end
      end
      if (acc && fs) r_arm = 1;
    end
  endtask

  task automatic tick(bit fs, bit rb);
    @(negedge clk); #1;
    tx_fs = fs; rx_fs = fs; rx_dat = rb;
    repeat (4) @(negedge clk);
    #1;
    tx_clk = 1; rx_clk = 1;
    model_rise(fs, rb);
    quiet = 6;
    repeat (4) @(negedge clk);
    #1;
    tx_clk = 0; rx_clk = 0;
  endtask

  task automatic data_ticks(logic [7:0] w, bit next_fs);
    for (int i = 7; i >= 0; i--) tick(next_fs && i == 0, w[i]);
  endtask

  task automatic send_frame(logic [7:0] w, bit next_fs);
    tick(1'b1, 1'b0);
    data_ticks(w, next_fs);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); #1;
    quiet = 6;
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    case (a)
      2'd1: if (m_tx_en) t_pend = int'(d[7:0]);
      2'd2: begin
        m_tx_en = d[0]; m_rx_en = d[1];
        if (!d[0]) begin
          t_pend = -1; t_arm = 0; t_cnt = 0; t_act = 0; m_ufl = 0; t_last = 0; m_txd = 0;
        end
        if (!d[1]) begin
          rxq.delete(); r_arm = 0; r_cnt = 0; m_ovr = 0; r_sh = 0;
        end
      end
      2'd3: begin
        if (d[2]) m_ufl = 0;
        if (d[3]) m_ovr = 0;
      end
      default: ;
    endcase
    @(negedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk); #1;
    quiet = 6;
    reg_addr = a; reg_rd = 1;
    #1 v = int'(reg_rdata);
    if (a == 2'd0 && rxq.size() > 0) begin
      void'(rxq.pop_front());
      if (rxq.size() > 0) m_rxevt++;
    end
    @(negedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(2'd2, v); chk("R1 ctrl after reset", v, 0);
    rd(2'd3, v); chk("R1 status after reset", v, 0);
    chk("R1 tx_dat_o", int'(tx_dat), 0);
    chk("R1 ready outputs", int'({tx_ready, rx_ready}), 0);
    run = 1;

    wr(2'd2, 32'h3); settle();
    chk("R4 R10 tx_ready after enable", int'(tx_ready), 1);

    // basic word each way
    wr(2'd1, 32'hA5);
    send_frame(8'h3C, 1'b0);
    tick(1'b0, 1'b0);
    settle();
    rd(2'd0, v); chk("R6 rx word", v & 255, 32'h3C);
    settle();
    chk("R4 tx_evt count", n_txevt, m_txevt);
    chk("R6 rx_evt count", n_rxevt, m_rxevt);
    rd(2'd3, v); chk("R5 no underflow yet", v, exp_stat());

    // underflow repeats last word
    send_frame(8'h5A, 1'b0);
    tick(1'b0, 1'b0);
    settle();
    rd(2'd3, v); chk("R5 underflow status", v, exp_stat());
    chk("R5 underflow bit", (v >> 2) & 1, 1);
    rd(2'd0, v); chk("R6 second rx word", v & 255, 32'h5A);
    wr(2'd3, 32'h4); settle();
    rd(2'd3, v); chk("R9 underflow cleared", v, exp_stat());
    chk("R9 underflow bit 0", (v >> 2) & 1, 0);

    // back-to-back, overrun, two-deep receive
    wr(2'd1, 32'h81);
    send_frame(8'h11, 1'b1);
    wr(2'd1, 32'h7E);
    data_ticks(8'h22, 1'b1);
    data_ticks(8'h33, 1'b0);
    tick(1'b0, 1'b0);
    settle();
    rd(2'd3, v); chk("R8 overrun status", v, exp_stat());
    chk("R8 overrun bit", (v >> 3) & 1, 1);
    chk("R5 R2 underflow on third back-to-back", (v >> 2) & 1, 1);
    rd(2'd0, v); chk("R7 first queued word", v & 255, 32'h11);
    settle();
    chk("R7 buffer moved up", int'(rx_ready), 1);
    rd(2'd0, v); chk("R7 second queued word", v & 255, 32'h22);
    settle();
    chk("R8 third word dropped", int'(rx_ready), 0);
    rd(2'd3, v); chk("R8 overrun still set", (v >> 3) & 1, 1);
    wr(2'd3, 32'h8); settle();
    rd(2'd3, v); chk("R9 overrun cleared only", v, exp_stat());
    wr(2'd3, 32'h4); settle();
    chk("R6 rx_evt count after queue", n_rxevt, m_rxevt);
    chk("R4 tx_evt count after queue", n_txevt, m_txevt);

    // frame sync inside a word is ignored
    wr(2'd1, 32'hC3);
    tick(1'b1, 1'b0);
    for (int i = 7; i >= 0; i--) tick(i == 4, 8'h96 >> i & 1);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    settle();
    chk("R2 no restart after mid-word sync", int'(tx_dat), 0);
    rd(2'd0, v); chk("R2 rx word with mid sync", v & 255, 32'h96);
    settle();
    chk("R2 no extra rx word", int'(rx_ready), 0);

    // enables
    wr(2'd2, 32'h2); settle();
    chk("R10 tx off not ready", int'(tx_ready), 0);
    wr(2'd1, 32'h55);
    wr(2'd2, 32'h3); settle();
    chk("R10 write while off ignored", int'(tx_ready), 1);
    send_frame(8'h0F, 1'b0);
    tick(1'b0, 1'b0);
    settle();
    rd(2'd3, v); chk("R10 R5 underflow after re-enable", v, exp_stat());
    chk("R10 rx word waiting", int'(rx_ready), 1);
    wr(2'd2, 32'h1); settle();
    chk("R10 rx off clears ready", int'(rx_ready), 0);
    wr(2'd2, 32'h3); settle();
    rd(2'd3, v); chk("R10 status after rx re-enable", v, exp_stat());
    rd(2'd2, v); chk("R10 ctrl readback", v, 3);

    run = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule